// File: doc/BRIEF.md
# I2C Slave Address Matcher with Don't-Care Mask

This block watches a synchronised I2C bus for a START condition, shifts in the address byte(s) and compares them with a programmed own-address under a 5-bit mask. Each set mask bit turns one position of the own-address into a don't-care, so one slave can answer a whole group of addresses. On a hit it pulls SDA low through an open-drain enable during the acknowledge clock. It also raises a one-cycle match pulse and stores the received byte so software can tell which member of the group was addressed.

Two addressing formats are supported, chosen by `mode_10b`. In 7-bit mode the own-address sits in `own_lo[7:1]`, in the same position as the received byte, with bit 0 carrying the read/write flag. In 10-bit mode a header byte carrying address bits 9:8 must match exactly. After it, the low address byte is compared under a different mask mapping. A later repeated START with a read header is accepted only when the preceding 10-bit address phase matched. That acceptance puts the slave in transmit state. Data bytes after the address, clock stretching and general call are handled elsewhere.

Top module: `i2c_addr_match`

## Requirements
- R1: After reset `sda_oe`, `match_irq`, `xmit` and `addr_buf` are all 0.
- R2: In 7-bit mode a received byte matches when, for every position n in 1..7, either n ≤ 5 and `addr_mask[n-1]`=1, or the received bit n equals `own_lo[n]`; bits 7 and 6 are always compared and bit 0 (R/W) is never compared. With `own_lo`=0xA0 and mask 5'b00111 exactly the bytes 0xA0..0xAF (either R/W) match.
- R3: On a matching byte `sda_oe` is 1 during the high phase of the ninth SCL clock and returns to 0 after that clock's falling edge; it changes only while the synchronised SCL is low.
- R4: A non-matching address byte leaves `sda_oe` at 0 and gives no match pulse, and every further byte is ignored (no ACK) until the next START.
- R5: Each completed matching address phase gives exactly one `match_irq` pulse of one clock cycle, in the same cycle that `addr_buf` shows the received byte that matched.
- R6: In 10-bit mode the first byte must equal 11110, `own_hi[1:0]`, 0 exactly (no masking); it is acknowledged without a match pulse, and any other first byte is not acknowledged.
- R7: In 10-bit mode the low address byte matches when bits 7:6 equal `own_lo[7:6]`, each bit n in 5..2 equals `own_lo[n]` unless `addr_mask[n-1]`=1, and bits 1:0 equal `own_lo[1:0]` unless `addr_mask[0]`=1 (one mask bit covers both). With `own_lo`=0xA0 and mask 5'b00111, 0xA0..0xAF all match.
- R8: In 10-bit mode a repeated START followed by the header 11110, `own_hi`, 1 is acknowledged, pulses `match_irq` and sets `xmit` to 1 only when the previous 10-bit address phase matched.
- R9: A STOP (SDA rising while SCL high) clears the address state, so a later read header after a fresh START is not acknowledged.
- R10: In 7-bit mode `xmit` after a match equals bit 0 of the matched byte; START and STOP clear `xmit`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| sda_oe | output | 1 | 1 pulls SDA low (ACK) |
| mode_10b | input | 1 | 1 selects 10-bit addressing |
| own_lo | input | 8 | Own-address: bits 7:1 in 7-bit mode, low byte in 10-bit mode |
| own_hi | input | 2 | Own-address bits 9:8 (10-bit mode) |
| addr_mask | input | 5 | Don't-care mask; bit k relates to address bit k+1 |
| match_irq | output | 1 | One-cycle pulse per matched address phase |
| addr_buf | output | 8 | Last matched address byte |
| xmit | output | 1 | Slave addressed for read (transmit state) |

## Verification
The bench builds the matcher with three synchroniser stages instead of the default two. Its bus phases last eight clocks, which is well above the deeper latency, so the acknowledge window and the release after the ninth falling edge are both observed with margin. The bench's masks are 5'b00111, 5'b11111 and 5'b00001. Together they expose the 7-bit alignment, the forced compare of the top two bits and the paired low-bit mask of 10-bit mode. The repeated-START and STOP sequences reach both outcomes of the read-header rule.

// File: rtl/i2c_am_pkg.sv
package i2c_am_pkg;
  localparam int BYTE_W = 8;
  localparam int MASK_W = 5;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_RX_FIRST,
    ST_RX_LOW,
    ST_HOLD
  } am_state_t;

  // positions that must compare in 7-bit mode: bits 7:6 always, 5:1 unless masked, bit 0 is R/W
  function automatic logic hit_7b(input logic [BYTE_W-1:0] rx,
                                  input logic [BYTE_W-1:0] own,
                                  input logic [MASK_W-1:0] msk);
    logic [BYTE_W-1:0] care;
    care = {2'b11, ~msk, 1'b0};
    return ((rx ^ own) & care) == '0;
  endfunction

  // 10-bit low byte: mask[4:1] -> bits 5:2, mask[0] -> bits 1:0
  function automatic logic hit_10b_lo(input logic [BYTE_W-1:0] rx,
                                      input logic [BYTE_W-1:0] own,
                                      input logic [MASK_W-1:0] msk);
    logic [BYTE_W-1:0] care;
    care = {2'b11, ~msk[4:1], {2{~msk[0]}}};
    return ((rx ^ own) & care) == '0;
  endfunction

  // 10-bit header: 11110 A9 A8, R/W ignored here
  function automatic logic hdr_ok(input logic [BYTE_W-1:0] rx,
                                  input logic [1:0] hi);
    return (rx[7:3] == 5'b11110) && (rx[2:1] == hi);
  endfunction
endpackage

// File: rtl/i2c_am_sync.sv
module i2c_am_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic sda_s,
  output logic start_evt,
  output logic stop_evt
);
  logic [STAGES-1:0] scl_chain, sda_chain;
  logic scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_chain <= '1;
      sda_chain <= '1;
      scl_q     <= 1'b1;
      sda_q     <= 1'b1;
    end else begin
      scl_chain <= {scl_chain[STAGES-2:0], scl_i};
      sda_chain <= {sda_chain[STAGES-2:0], sda_i};
      scl_q     <= scl_chain[STAGES-1];
      sda_q     <= sda_chain[STAGES-1];
    end
  end

  assign scl_s     = scl_chain[STAGES-1];
  assign sda_s     = sda_chain[STAGES-1];
  assign scl_rise  = scl_s & ~scl_q;
  assign scl_fall  = ~scl_s & scl_q;
  assign start_evt = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_evt  = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/i2c_am_shift.sv
module i2c_am_shift #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             scl_rise,
  input  logic             sda_s,
  output logic [WIDTH-1:0] byte_q,
  output logic             full
);
  localparam int CNT_W = $clog2(WIDTH + 1);
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt    <= '0;
      byte_q <= '0;
    end else if (clr) begin
      cnt <= '0;
    end else if (scl_rise && !full) begin
      byte_q <= {byte_q[WIDTH-2:0], sda_s};
      cnt    <= cnt + 1'b1;
    end
  end

  assign full = (cnt == CNT_W'(WIDTH));
endmodule

// File: rtl/i2c_addr_match.sv
module i2c_addr_match
  import i2c_am_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe,
  input  logic              mode_10b,
  input  logic [BYTE_W-1:0] own_lo,
  input  logic [1:0]        own_hi,
  input  logic [MASK_W-1:0] addr_mask,
  output logic              match_irq,
  output logic [BYTE_W-1:0] addr_buf,
  output logic              xmit
);
  // named internal events, also used by the bound checker
  logic scl_s, sda_s, scl_rise, scl_fall, start_evt, stop_evt;
  logic [BYTE_W-1:0] rx_byte;
  logic rx_full, byte_end, ack_end, shift_clr, in_idle;
  logic hit10;
  am_state_t st;

  // decision for the byte just completed
  logic ack_now, irq_now, xmit_now, hit10_now;
  am_state_t nxt;

  i2c_am_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_s(scl_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .sda_s(sda_s), .start_evt(start_evt), .stop_evt(stop_evt)
  );

  i2c_am_shift #(.WIDTH(BYTE_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .clr(shift_clr), .scl_rise(scl_rise),
    .sda_s(sda_s), .byte_q(rx_byte), .full(rx_full)
  );

  assign in_idle   = (st == ST_IDLE);
  assign byte_end  = scl_fall && rx_full && !sda_oe &&
                     ((st == ST_RX_FIRST) || (st == ST_RX_LOW));
  assign ack_end   = scl_fall && sda_oe;
  assign shift_clr = start_evt | stop_evt | ack_end;

  always_comb begin
    ack_now   = 1'b0;
    irq_now   = 1'b0;
    xmit_now  = 1'b0;
    hit10_now = 1'b0;
    nxt       = ST_HOLD;
    if (st == ST_RX_FIRST) begin
      if (!mode_10b) begin
        ack_now  = hit_7b(rx_byte, own_lo, addr_mask);
        irq_now  = ack_now;
        xmit_now = rx_byte[0];
      end else if (hdr_ok(rx_byte, own_hi)) begin
        if (!rx_byte[0]) begin
          ack_now = 1'b1;
          nxt     = ST_RX_LOW;
        end else begin
          ack_now   = hit10;
          irq_now   = hit10;
          xmit_now  = 1'b1;
          hit10_now = hit10;
        end
      end
    end else if (st == ST_RX_LOW) begin
      ack_now   = hit_10b_lo(rx_byte, own_lo, addr_mask);
      irq_now   = ack_now;
      hit10_now = ack_now;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= ST_IDLE;
      sda_oe    <= 1'b0;
      match_irq <= 1'b0;
      addr_buf  <= '0;
      xmit      <= 1'b0;
      hit10     <= 1'b0;
    end else if (stop_evt) begin
      st        <= ST_IDLE;
      sda_oe    <= 1'b0;
      match_irq <= 1'b0;
      xmit      <= 1'b0;
      hit10     <= 1'b0;
    end else if (start_evt) begin
      st        <= ST_RX_FIRST;
      sda_oe    <= 1'b0;
      match_irq <= 1'b0;
      xmit      <= 1'b0;
    end else begin
      match_irq <= 1'b0;
      if (byte_end) begin
        hit10 <= hit10_now;
        if (ack_now) begin
          sda_oe    <= 1'b1;
          st        <= nxt;
          match_irq <= irq_now;
          if (irq_now) begin
            addr_buf <= rx_byte;
            xmit     <= xmit_now;
          end
        end else begin
          st <= ST_IDLE;
        end
      end else if (ack_end) begin
        sda_oe <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/i2c_am_chk.sv
module i2c_am_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       scl_s,
  input logic       stop_evt,
  input logic       in_idle,
  input logic       hit10,
  input logic       sda_oe,
  input logic       match_irq,
  input logic       xmit,
  input logic       mode_10b,
  input logic [7:0] addr_buf,
  input logic [7:0] own_lo
);
  p_oe_rise_scl_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> !scl_s);

  p_irq_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
    match_irq |=> !match_irq);

  p_irq_with_ack_r5: assert property (@(posedge clk) disable iff (!rst_n)
    match_irq |-> sda_oe);

  p_idle_no_ack_r4: assert property (@(posedge clk) disable iff (!rst_n)
    in_idle |-> !sda_oe);

  p_stop_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
    stop_evt |=> (!sda_oe && !hit10 && !xmit));

  p_read_needs_hit_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(xmit) && mode_10b) |-> hit10);

  p_top_bits_exact_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (match_irq && !mode_10b) |-> (addr_buf[7:6] == own_lo[7:6]));
endmodule

bind i2c_addr_match i2c_am_chk u_chk (
  .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .stop_evt(stop_evt),
  .in_idle(in_idle), .hit10(hit10), .sda_oe(sda_oe),
  .match_irq(match_irq), .xmit(xmit), .mode_10b(mode_10b),
  .addr_buf(addr_buf), .own_lo(own_lo)
);

// File: tb/sim_i2c_addr_match.sv
module sim_i2c_addr_match;
  localparam int CLK_PERIOD = 10;
  localparam int Q = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_drv = 1'b1, sda_drv = 1'b1;
  logic mode_10b = 1'b0;
  logic [7:0] own_lo = 8'hA0;
  logic [1:0] own_hi = 2'b10;
  logic [4:0] addr_mask = 5'b00111;
  logic sda_oe, match_irq, xmit;
  logic [7:0] addr_buf;
  logic sda_line;

  int n_tests = 0, n_fail = 0, irq_cnt = 0, irq_wide = 0;
  logic irq_prev = 1'b0;
  logic acked, released;

  always #(CLK_PERIOD/2) clk = ~clk;
  assign sda_line = sda_drv & ~sda_oe;

  i2c_addr_match #(.SYNC_STAGES(3)) u0 (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_drv), .sda_i(sda_line),
    .sda_oe(sda_oe), .mode_10b(mode_10b), .own_lo(own_lo), .own_hi(own_hi),
    .addr_mask(addr_mask), .match_irq(match_irq), .addr_buf(addr_buf), .xmit(xmit)
  );

  always @(negedge clk) begin
    if (match_irq) irq_cnt++;
    if (match_irq && irq_prev) irq_wide++;
    irq_prev = match_irq;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog: run did not complete, actual=hung expected=done");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic w(input int n);
    repeat (n) @(negedge clk);
  endtask

  // reference: bitwise walk, not the RTL's mask vector
  function automatic bit ref7(input logic [7:0] b);
    for (int i = 1; i < 8; i++) begin
      bit dc = (i <= 5) && addr_mask[i-1];
      if (!dc && b[i] != own_lo[i]) return 0;
    end
    return 1;
  endfunction

  function automatic bit ref10lo(input logic [7:0] b);
    for (int i = 0; i < 8; i++) begin
      bit dc = (i >= 2 && i <= 5) ? addr_mask[i-1] : (i <= 1 ? addr_mask[0] : 1'b0);
      if (!dc && b[i] != own_lo[i]) return 0;
    end
    return 1;
  endfunction

  task automatic bus_start();
    sda_drv = 1'b1; w(Q); scl_drv = 1'b1; w(Q);
    sda_drv = 1'b0; w(2*Q); scl_drv = 1'b0; w(Q);
  endtask

  task automatic bus_stop();
    sda_drv = 1'b0; w(Q); scl_drv = 1'b1; w(Q);
    sda_drv = 1'b1; w(2*Q);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack, output logic rel);
    for (int i = 7; i >= 0; i--) begin
      sda_drv = b[i]; w(Q); scl_drv = 1'b1; w(2*Q); scl_drv = 1'b0; w(Q);
    end
    sda_drv = 1'b1; w(Q); scl_drv = 1'b1; w(Q);
    ack = sda_oe; w(Q);
    scl_drv = 1'b0; w(Q);
    rel = ~sda_oe;
  endtask

  // one 7-bit address phase checked against the model
  task automatic try7(input logic [7:0] b);
    int c0;
    bit exp;
    exp = ref7(b);
    c0 = irq_cnt;
    bus_start();
    send_byte(b, acked, released);
    chk(acked == exp, "R2 7-bit ack", acked, exp);
    chk(released, "R3 release after ninth fall", sda_oe, 0);
    chk(irq_cnt - c0 == int'(exp), "R5 irq count", irq_cnt - c0, exp);
    if (exp) begin
      chk(addr_buf == b, "R5 addr_buf", addr_buf, b);
      chk(xmit == b[0], "R10 xmit from R/W", xmit, b[0]);
    end else begin
      send_byte(own_lo, acked, released);
      chk(!acked, "R4 ignored until START", acked, 0);
    end
    bus_stop();
    chk(!xmit, "R10 xmit cleared by STOP", xmit, 0);
  endtask

  initial begin
    int c0;
    w(3);
    chk(!sda_oe && !match_irq && !xmit && addr_buf == 0, "R1 reset state",
        {sda_oe, match_irq, xmit}, 0);
    chk(addr_buf == 8'h00, "R1 addr_buf reset", addr_buf, 0);
    rst_n = 1'b1;
    w(4);

    // 7-bit, mask 00111
    try7(8'hA0); try7(8'hA2); try7(8'hAE); try7(8'hA1);
    try7(8'hB0); try7(8'h20); try7(8'hE0); try7(8'hA8);
    // 7-bit, all mask bits set: only bits 7:6 compared
    addr_mask = 5'b11111;
    try7(8'hBE); try7(8'h80); try7(8'hE0);
    addr_mask = 5'b00111;

    // 10-bit mode
    mode_10b = 1'b1;
    for (int lo = 8'h9E; lo <= 8'hB1; lo += 3) begin
      bit exp;
      exp = ref10lo(8'(lo));
      c0 = irq_cnt;
      bus_start();
      send_byte(8'hF4, acked, released);
      chk(acked, "R6 header write ack", acked, 1);
      chk(irq_cnt == c0, "R6 no irq on header", irq_cnt - c0, 0);
      send_byte(8'(lo), acked, released);
      chk(acked == exp, "R7 low byte ack", acked, exp);
      chk(irq_cnt - c0 == int'(exp), "R5 irq count 10-bit", irq_cnt - c0, exp);
      if (exp) chk(addr_buf == 8'(lo), "R5 addr_buf 10-bit", addr_buf, lo);
      // repeated START with read header
      c0 = irq_cnt;
      bus_start();
      send_byte(8'hF5, acked, released);
      chk(acked == exp, "R8 read header after repeated START", acked, exp);
      chk(xmit == exp, "R8 xmit", xmit, exp);
      chk(irq_cnt - c0 == int'(exp), "R8 irq on read header", irq_cnt - c0, exp);
      bus_stop();
    end
    // every low byte 0xA0..0xAF acknowledged
    for (int lo = 8'hA0; lo <= 8'hAF; lo++) begin
      bus_start();
      send_byte(8'hF4, acked, released);
      send_byte(8'(lo), acked, released);
      chk(acked, "R7 range A0..AF", acked, 1);
      bus_stop();
    end
    // wrong upper bits in header
    bus_start();
    send_byte(8'hF2, acked, released);
    chk(!acked, "R6 header mismatch", acked, 0);
    bus_stop();
    // STOP clears state: fresh START + read header refused
    bus_start();
    send_byte(8'hF5, acked, released);
    chk(!acked, "R9 read header after STOP", acked, 0);
    chk(!xmit, "R9 xmit stays 0", xmit, 0);
    bus_stop();
    // mask bit 0 covers both low bits in 10-bit mode
    addr_mask = 5'b00001;
    foreach (own_lo[i]) begin
      logic [7:0] lo;
      lo = 8'hA0 ^ (8'h1 << i);
      bus_start();
      send_byte(8'hF4, acked, released);
      send_byte(lo, acked, released);
      chk(acked == ref10lo(lo), "R7 paired low mask", acked, ref10lo(lo));
      bus_stop();
    end
    bus_start();
    send_byte(8'hF4, acked, released);
    send_byte(8'hA3, acked, released);
    chk(acked, "R7 A3 with mask 00001", acked, 1);
    bus_stop();

    chk(irq_wide == 0, "R5 irq one cycle wide", irq_wide, 0);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule